// File: doc/BRIEF.md
# Fetch-Packet Branch Target Buffer

This block sits in the fetch stage of a superscalar front end and predicts, in the same cycle, where the next fetch packet should come from. Each cycle it compares the current fetch address against the tags of all stored entries in parallel. On a hit against a valid entry it supplies the next fetch address, so a correct prediction costs no bubble. It also reports the control-flow kind of the entry, the slot of the instruction that causes the redirect, and a per-slot valid mask that removes the instructions after that slot.

Each entry is tagged by the address of the whole fetch packet rather than by the address of the branch inside it. One entry therefore describes exactly one control-flow instruction for its packet. The stored kind decides how the final prediction is formed. A conditional branch takes its direction from an external direction input. A return takes its target from an external return-stack input. An unconditional jump is always taken.

Entries are written only from the redirect port, which the pipeline drives when it steers fetch toward a taken branch or jump. A redirect whose fetch address already has an entry rewrites that entry. Any other redirect allocates a new entry: an invalid entry is used first, and otherwise a round-robin victim is replaced.

Top module: `pkt_btb`

## Requirements
- R1: A lookup hits only when some entry is valid and its tag equals `fetch_addr`. At most one entry ever hits. On a miss, `hit` is 0 and `hit_kind` and `hit_slot` are 0.
- R2: On a hit whose kind is conditional (code 2'b00) and with `dir_taken`=1, `redirect` is 1 and `next_addr` equals the stored target in the same cycle as `fetch_addr`. With `dir_taken`=0 the prediction is not taken.
- R3: On a hit whose kind is return (code 2'b10), `redirect` is 1 and `next_addr` equals `ras_target`, not the stored target.
- R4: On a hit whose kind is jump (code 2'b01, and code 2'b11 is treated the same way), `redirect` is 1 and `next_addr` is the stored target, whatever the value of `dir_taken`.
- R5: With no hit, or with a not-taken conditional, `redirect` is 0 and `next_addr` equals `fetch_addr` + SLOTS*INSN_BYTES (16 by default, wrapping modulo 2^ADDR_W). `dir_taken` and `ras_target` have no effect on the outputs in this case.
- R6: When `redirect` is 1, bit i of `slot_valid` is 1 exactly for i <= `hit_slot`. Otherwise all bits of `slot_valid` are 1. On a hit, `hit_kind` and `hit_slot` report the stored kind and slot.
- R7: A write whose `wr_fetch_addr` matches a valid entry overwrites that entry in place and leaves every other entry unchanged.
- R8: A write that matches no entry goes into the lowest-indexed invalid entry if one exists, and otherwise into the entry at a round-robin pointer. The pointer starts at 0 and advances by one, wrapping at ENTRIES, on every such new allocation.
- R9: A lookup in the same cycle as a write sees the old contents. The written entry is visible from the next cycle on.
- R10: A synchronous active-low reset clears every valid bit and the round-robin pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | ADDR_W | Current fetch-packet address |
| dir_taken | input | 1 | Direction from the external direction predictor |
| ras_target | input | ADDR_W | Top of the external return stack |
| wr_en | input | 1 | Redirect write strobe |
| wr_fetch_addr | input | ADDR_W | Fetch-packet address of the redirecting instruction |
| wr_target | input | ADDR_W | Target of the redirect |
| wr_kind | input | 2 | Kind: 00 conditional, 01 jump, 10 return, 11 jump |
| wr_slot | input | $clog2(SLOTS) | Slot of the redirecting instruction in its packet |
| hit | output | 1 | Lookup hit |
| hit_kind | output | 2 | Kind of the hit entry, 0 on a miss |
| hit_slot | output | $clog2(SLOTS) | Slot of the hit entry, 0 on a miss |
| redirect | output | 1 | Predicted taken |
| next_addr | output | ADDR_W | Predicted next fetch address |
| slot_valid | output | SLOTS | Per-slot valid mask of the current packet |

## Verification
A corrupted tag or a stale valid bit shows up in the same cycle that its address is presented. The block then either falls through to the sequential address where a redirect was due, or redirects where none was due. A wrong victim choice stays hidden until the evicted address is looked up again. The bench therefore replays the whole address pool against a reference model after fills and overwrites. A wrong stored kind or slot appears at once as the wrong source for `next_addr` or as a mask cut at the wrong slot.

// File: rtl/pkt_btb_pkg.sv
// Shared encodings for the fetch-packet branch target buffer.
// Assumes a 2-bit control-flow kind field written by the redirect port.
package pkt_btb_pkg;
    localparam int KIND_W = 2;
    localparam logic [KIND_W-1:0] KIND_COND = 2'b00;
    localparam logic [KIND_W-1:0] KIND_JUMP = 2'b01;
    localparam logic [KIND_W-1:0] KIND_RET  = 2'b10;
endpackage

// File: rtl/pkt_btb_match.sv
// Parallel tag comparator: one equality compare per entry, qualified by valid.
// Assumes at most one entry matches (the writer never duplicates a tag).
module pkt_btb_match #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]              key,
    output logic [ENTRIES-1:0]             hit_vec,
    output logic                           any_hit,
    output logic [IDX_W-1:0]               hit_idx
);
    // Per-entry compare, replicated across the array (R1).
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit_vec[e] = valid[e] && (tags[e] == key);
    end

    assign any_hit = |hit_vec;

    // Encode the matching entry into an index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pkt_btb_victim.sv
// Victim selection for new allocations: the lowest invalid entry, else the round-robin pointer.
// Assumes the pointer is maintained by the caller (R8).
module pkt_btb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   victim
);
    // Scan downward so that the lowest invalid index wins.
    always_comb begin
        victim = rr_ptr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) victim = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pkt_btb_resolve.sv
// Final prediction: combines the hit entry with the direction and return-stack inputs,
// and builds the next fetch address and the slot mask. Purely combinational.
module pkt_btb_resolve
    import pkt_btb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SLOTS      = 4,
    parameter int INSN_BYTES = 4,
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int PKT_BYTES = SLOTS * INSN_BYTES
) (
    input  logic                hit,
    input  logic [KIND_W-1:0]   ent_kind,
    input  logic [SLOT_W-1:0]   ent_slot,
    input  logic [ADDR_W-1:0]   ent_target,
    input  logic                dir_taken,
    input  logic [ADDR_W-1:0]   ras_target,
    input  logic [ADDR_W-1:0]   fetch_addr,
    output logic                redirect,
    output logic [ADDR_W-1:0]   next_addr,
    output logic [SLOTS-1:0]    slot_valid,
    output logic [KIND_W-1:0]   kind_o,
    output logic [SLOT_W-1:0]   slot_o
);
    // Taken decision: the direction input matters only for a conditional hit (R2, R4, R5).
    always_comb begin
        redirect = 1'b0;
        if (hit) begin
            if (ent_kind == KIND_COND) redirect = dir_taken;
            else                       redirect = 1'b1;
        end
    end

    // Target source: the return stack for returns, else the stored target (R3).
    always_comb begin
        next_addr = fetch_addr + ADDR_W'(PKT_BYTES);
        if (redirect) next_addr = (ent_kind == KIND_RET) ? ras_target : ent_target;
    end

    // Slot mask: slots after the redirecting one are dropped (R6).
    for (genvar s = 0; s < SLOTS; s++) begin : g_mask
        assign slot_valid[s] = !redirect || (int'(ent_slot) >= s);
    end

    assign kind_o = hit ? ent_kind : '0;
    assign slot_o = hit ? ent_slot : '0;
endmodule

// File: rtl/pkt_btb.sv
// Fully associative branch target buffer tagged by fetch-packet address.
// Lookup is combinational from fetch_addr and the registered entries. Writes come from the
// redirect port and take effect at the next clock edge. Assumes the caller writes only taken
// redirects and that ENTRIES and SLOTS are at least 2.
module pkt_btb
    import pkt_btb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 8,
    parameter int SLOTS      = 4,
    parameter int INSN_BYTES = 4,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   fetch_addr,
    input  logic                dir_taken,
    input  logic [ADDR_W-1:0]   ras_target,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_fetch_addr,
    input  logic [ADDR_W-1:0]   wr_target,
    input  logic [KIND_W-1:0]   wr_kind,
    input  logic [SLOT_W-1:0]   wr_slot,
    output logic                hit,
    output logic [KIND_W-1:0]   hit_kind,
    output logic [SLOT_W-1:0]   hit_slot,
    output logic                redirect,
    output logic [ADDR_W-1:0]   next_addr,
    output logic [SLOTS-1:0]    slot_valid
);
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tgt_q;
    logic [ENTRIES-1:0][KIND_W-1:0] kind_q;
    logic [ENTRIES-1:0][SLOT_W-1:0] slot_q;
    logic [IDX_W-1:0]               ptr_q;

    logic [ENTRIES-1:0] look_hit_vec, wr_hit_vec;
    logic               wr_hit;
    logic [IDX_W-1:0]   look_idx, wr_match_idx, victim_idx, wr_idx;

    // Lookup-side tag compare against the fetch address.
    pkt_btb_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_look (
        .valid(valid_q), .tags(tag_q), .key(fetch_addr),
        .hit_vec(look_hit_vec), .any_hit(hit), .hit_idx(look_idx)
    );

    // Write-side tag compare, used to find an existing entry to overwrite (R7).
    pkt_btb_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_wmatch (
        .valid(valid_q), .tags(tag_q), .key(wr_fetch_addr),
        .hit_vec(wr_hit_vec), .any_hit(wr_hit), .hit_idx(wr_match_idx)
    );

    // Victim for a new allocation (R8).
    pkt_btb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid(valid_q), .rr_ptr(ptr_q), .victim(victim_idx)
    );

    assign wr_idx = wr_hit ? wr_match_idx : victim_idx;

    // Final prediction from the hit entry.
    pkt_btb_resolve #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .INSN_BYTES(INSN_BYTES)) u_resolve (
        .hit(hit), .ent_kind(kind_q[look_idx]), .ent_slot(slot_q[look_idx]),
        .ent_target(tgt_q[look_idx]), .dir_taken(dir_taken), .ras_target(ras_target),
        .fetch_addr(fetch_addr), .redirect(redirect), .next_addr(next_addr),
        .slot_valid(slot_valid), .kind_o(hit_kind), .slot_o(hit_slot)
    );

    // Valid bits and the round-robin pointer: cleared by reset, updated by writes (R8, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            if (!wr_hit) ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // Entry payload: written at the edge, so a same-cycle lookup sees the old data (R9).
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) begin
            tag_q[wr_idx]  <= wr_fetch_addr;
            tgt_q[wr_idx]  <= wr_target;
            kind_q[wr_idx] <= wr_kind;
            slot_q[wr_idx] <= wr_slot;
        end
    end
endmodule

// File: rtl/pkt_btb_checker.sv
// Property checker for pkt_btb, attached with bind. It observes the ports and the lookup hit vector.
module pkt_btb_checker
    import pkt_btb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 8,
    parameter int SLOTS      = 4,
    parameter int INSN_BYTES = 4,
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int PKT_BYTES = SLOTS * INSN_BYTES
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   fetch_addr,
    input logic [ADDR_W-1:0]   ras_target,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_fetch_addr,
    input logic [KIND_W-1:0]   wr_kind,
    input logic [SLOT_W-1:0]   wr_slot,
    input logic                hit,
    input logic [KIND_W-1:0]   hit_kind,
    input logic [SLOT_W-1:0]   hit_slot,
    input logic                redirect,
    input logic [ADDR_W-1:0]   next_addr,
    input logic [SLOTS-1:0]    slot_valid,
    input logic [ENTRIES-1:0]  hit_vec
);
    assert_unique_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_ret_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_kind == KIND_RET) |-> (redirect && next_addr == ras_target));

    assert_jump_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_kind[0]) |-> redirect);

    assert_miss_fallthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (!redirect && next_addr == fetch_addr + ADDR_W'(PKT_BYTES) && &slot_valid));

    assert_slot_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> ($countones(slot_valid) == int'(hit_slot) + 1 && slot_valid[0]));

    assert_write_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && rst_n) && fetch_addr == $past(wr_fetch_addr))
        |-> (hit && hit_kind == $past(wr_kind) && hit_slot == $past(wr_slot)));

    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !hit);
endmodule

bind pkt_btb pkt_btb_checker #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .SLOTS(SLOTS), .INSN_BYTES(INSN_BYTES)
) u_pkt_btb_checker (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .ras_target(ras_target),
    .wr_en(wr_en), .wr_fetch_addr(wr_fetch_addr), .wr_kind(wr_kind), .wr_slot(wr_slot),
    .hit(hit), .hit_kind(hit_kind), .hit_slot(hit_slot), .redirect(redirect),
    .next_addr(next_addr), .slot_valid(slot_valid), .hit_vec(look_hit_vec)
);

// File: tb/pkt_btb_bench.sv
`timescale 1ns/1ps
module pkt_btb_bench;
    import pkt_btb_pkg::*;
    localparam int ADDR_W = 32, ENTRIES = 8, SLOTS = 4, INSN_BYTES = 4;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int PKT = SLOTS * INSN_BYTES;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [ADDR_W-1:0] fetch_addr = '0, ras_target = '0, wr_fetch_addr = '0, wr_target = '0;
    logic dir_taken = 1'b0, wr_en = 1'b0;
    logic [KIND_W-1:0] wr_kind = '0;
    logic [SLOT_W-1:0] wr_slot = '0;
    logic hit, redirect;
    logic [KIND_W-1:0] hit_kind;
    logic [SLOT_W-1:0] hit_slot;
    logic [ADDR_W-1:0] next_addr;
    logic [SLOTS-1:0] slot_valid;

    int checks = 0, errors = 0;

    // Reference model of the entries.
    logic [ADDR_W-1:0] m_tag [ENTRIES];
    logic [ADDR_W-1:0] m_tgt [ENTRIES];
    logic [KIND_W-1:0] m_kind [ENTRIES];
    logic [SLOT_W-1:0] m_slot [ENTRIES];
    logic              m_val [ENTRIES];
    int                m_ptr;

    always #2 clk = ~clk;

    pkt_btb u_pkt_btb (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .dir_taken(dir_taken),
        .ras_target(ras_target), .wr_en(wr_en), .wr_fetch_addr(wr_fetch_addr),
        .wr_target(wr_target), .wr_kind(wr_kind), .wr_slot(wr_slot), .hit(hit),
        .hit_kind(hit_kind), .hit_slot(hit_slot), .redirect(redirect),
        .next_addr(next_addr), .slot_valid(slot_valid)
    );

    function automatic int model_find(input logic [ADDR_W-1:0] a);
        for (int i = 0; i < ENTRIES; i++) if (m_val[i] && m_tag[i] == a) return i;
        return -1;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < ENTRIES; i++) m_val[i] = 1'b0;
        m_ptr = 0;
    endfunction

    // R7 overwrite in place, R8 lowest invalid then round-robin.
    function automatic void model_write(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] t,
                                        input logic [KIND_W-1:0] k, input logic [SLOT_W-1:0] s);
        int idx = model_find(a);
        if (idx < 0) begin
            idx = m_ptr;
            for (int i = ENTRIES - 1; i >= 0; i--) if (!m_val[i]) idx = i;
            m_ptr = (m_ptr + 1) % ENTRIES;
        end
        m_tag[idx] = a; m_tgt[idx] = t; m_kind[idx] = k; m_slot[idx] = s; m_val[idx] = 1'b1;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check before the rising edge, then update the model.
    task automatic step(input logic [ADDR_W-1:0] fa, input logic dir, input logic [ADDR_W-1:0] ras,
                        input logic we, input logic [ADDR_W-1:0] wa, input logic [ADDR_W-1:0] wt,
                        input logic [KIND_W-1:0] wk, input logic [SLOT_W-1:0] ws, input string ctx);
        int idx;
        logic e_hit, e_red;
        logic [ADDR_W-1:0] e_next;
        logic [SLOTS-1:0] e_mask;
        logic [KIND_W-1:0] e_kind;
        logic [SLOT_W-1:0] e_slot;
        string req;
        @(negedge clk);
        fetch_addr = fa; dir_taken = dir; ras_target = ras;
        wr_en = we; wr_fetch_addr = wa; wr_target = wt; wr_kind = wk; wr_slot = ws;
        #1;
        idx = model_find(fa);
        e_hit = (idx >= 0);
        e_kind = e_hit ? m_kind[idx] : '0;
        e_slot = e_hit ? m_slot[idx] : '0;
        e_red = e_hit && ((e_kind == KIND_COND) ? dir : 1'b1);
        e_next = fa + ADDR_W'(PKT);
        e_mask = '1;
        if (!e_hit) req = "R5";
        else if (e_kind == KIND_COND) req = e_red ? "R2" : "R5";
        else if (e_kind == KIND_RET) req = "R3";
        else req = "R4";
        if (e_red) begin
            e_next = (e_kind == KIND_RET) ? ras : m_tgt[idx];
            for (int s = 0; s < SLOTS; s++) e_mask[s] = (s <= int'(e_slot));
        end
        check({"R1 ", ctx}, "hit", 64'(hit), 64'(e_hit));
        check({req, " ", ctx}, "redirect", 64'(redirect), 64'(e_red));
        check({req, " ", ctx}, "next_addr", 64'(next_addr), 64'(e_next));
        check({"R6 ", ctx}, "slot_valid", 64'(slot_valid), 64'(e_mask));
        check({"R6 ", ctx}, "kind", 64'(hit_kind), 64'(e_kind));
        check({"R6 ", ctx}, "slot", 64'(hit_slot), 64'(e_slot));
        @(posedge clk);
        if (we && rst_n) model_write(wa, wt, wk, ws);
    endtask

    task automatic look(input logic [ADDR_W-1:0] fa, input logic dir, input string ctx);
        step(fa, dir, 32'hCAFE_0000, 1'b0, '0, '0, '0, '0, ctx);
    endtask

    task automatic put(input logic [ADDR_W-1:0] wa, input logic [ADDR_W-1:0] wt,
                       input logic [KIND_W-1:0] wk, input logic [SLOT_W-1:0] ws);
        step(32'h0000_0F00, 1'b0, '0, 1'b1, wa, wt, wk, ws, "write");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [ADDR_W-1:0] pool(input int k);
        return 32'h0000_1000 + ADDR_W'(k * PKT);
    endfunction

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        do_reset();
        // R10: nothing hits after reset.
        for (int k = 0; k < 4; k++) look(pool(k), 1'b1, "R10 after reset");

        // R9: a write and a lookup of the same address in one cycle see the old contents.
        step(pool(0), 1'b1, 32'h5555_0000, 1'b1, pool(0), 32'h0000_8000, KIND_COND, 2'd1, "R9 same cycle");
        look(pool(0), 1'b1, "R9 next cycle, R2 taken");
        look(pool(0), 1'b0, "R5 conditional not taken");

        // R3: a return uses the return-stack input.
        put(pool(1), 32'h0000_9000, KIND_RET, 2'd3);
        step(pool(1), 1'b0, 32'h0000_ABC0, 1'b0, '0, '0, '0, '0, "R3 return");
        // R4: a jump ignores the direction input; code 11 also acts as a jump.
        put(pool(2), 32'h0000_A000, KIND_JUMP, 2'd0);
        look(pool(2), 1'b0, "R4 jump, direction 0");
        put(pool(3), 32'h0000_B000, 2'b11, 2'd2);
        look(pool(3), 1'b0, "R4 code 11");
        // R5: wrap of the sequential address.
        look(32'hFFFF_FFF0, 1'b1, "R5 wrap");

        // R7: overwrite in place.
        put(pool(0), 32'h0000_C000, KIND_JUMP, 2'd2);
        for (int k = 0; k < 4; k++) look(pool(k), 1'b1, "R7 overwrite");

        // R8: fill the rest, then evict by round robin.
        for (int k = 4; k < 10; k++) put(pool(k), 32'h0002_0000 + 32'(k), KIND_JUMP, 2'(k));
        for (int k = 0; k < 10; k++) look(pool(k), 1'b1, "R8 replacement");

        // R10: a reset in the middle of a run.
        do_reset();
        for (int k = 0; k < 10; k++) look(pool(k), 1'b1, "R10 mid-run reset");

        // Random mix over a small address pool.
        for (int n = 0; n < 3000; n++) begin
            logic we;
            we = ($urandom % 4) == 0;
            step(pool($urandom % 14), 1'($urandom), $urandom, we, pool($urandom % 14),
                 $urandom, 2'($urandom), 2'($urandom), "random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule